// File: doc/BRIEF.md
# RAM Write Guard for a CPU and a Coprocessor

This block sits beside the RAM write ports of two bus masters, a main CPU and a coprocessor, and decides in the same cycle whether each write attempt may reach the RAM. It has two programmable address windows. One is the coprocessor's private window and the other is a window shared by both masters. Each window is bounded by an inclusive lower and upper address register.

The guard treats the two masters differently. The CPU may write anywhere except the coprocessor's private window. A CPU write that lands there is blocked and raises a sticky violation flag, which can raise an interrupt. The coprocessor may write only inside its private window or the shared window. Any other coprocessor write is blocked without raising the flag.

Software sets the guard up over a simple register port. Turning the guard on also freezes the four boundary registers. The master write paths carry no handshake. A write request is a single-cycle strobe with an address, and the matching suppress output must gate the RAM write enable in that same cycle. The block therefore never applies back-pressure.

Top module: `ramwp_unit`

## Requirements
- R1: After reset the control register reads 0x0000, the interrupt request is 0 and no suppress output is active.
- R2: Control register (offset 0) fields are: guard enable at bit 7, interrupt enable at bit 1 and violation flag at bit 0. All other bits read as 0. Bits 7 and 1 are written directly.
- R3: While the guard enable is 0, neither suppress output is ever asserted, and writes to the boundary registers take effect and read back.
- R4: While the guard enable is 1, register-port writes to the boundary registers leave them unchanged.
- R5: While enabled, a CPU write whose address satisfies lo <= addr <= hi of the coprocessor window asserts the CPU suppress output in the same cycle and sets the violation flag from the next cycle on. CPU writes outside that window are not suppressed.
- R6: While enabled, a coprocessor write is suppressed in the same cycle exactly when its address lies outside both the coprocessor window and the shared window. Both bounds of each window are inclusive.
- R7: A suppressed coprocessor write never sets the violation flag.
- R8: Writing the control register with bit 0 = 1 clears the violation flag. Writing bit 0 = 0 leaves the flag unchanged.
- R9: When a CPU violation and a clearing control write happen in the same cycle, the flag is 1 afterwards.
- R10: The interrupt request is 1 exactly when both the interrupt enable and the violation flag are 1.
- R11: Register offsets are 0 for control, 1 and 2 for the coprocessor window lower and upper bounds, and 3 and 4 for the shared window lower and upper bounds. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| cpu_wr_req | input | 1 | CPU RAM write attempt |
| cpu_wr_addr | input | AW | CPU RAM write address |
| cpu_wr_block | output | 1 | Suppress the CPU RAM write this cycle |
| cop_wr_req | input | 1 | Coprocessor RAM write attempt |
| cop_wr_addr | input | AW | Coprocessor RAM write address |
| cop_wr_block | output | 1 | Suppress the coprocessor RAM write this cycle |
| irq | output | 1 | Violation interrupt request |

## Verification
The assertions check the following on every cycle:
- no write is blocked while the guard is off;
- a blocked CPU write always leaves the flag set;
- the boundary registers stay frozen while the guard is on;
- a blocked coprocessor write alone never raises a clear flag;
- the flag does not drop unless a clearing write occurred;
- the interrupt only rises with its enable set.

The bench scenarios cover what depends on chosen addresses and values. These are the inclusive window edges one address inside and one outside, the register map and zero-read bits, the write-0 no-op on the flag, and the same-cycle set-and-clear race.

// File: rtl/ramwp_pkg.sv
package ramwp_pkg;
  typedef enum logic [2:0] {
    OFS_CTRL   = 3'd0,
    OFS_COP_LO = 3'd1,
    OFS_COP_HI = 3'd2,
    OFS_SHR_LO = 3'd3,
    OFS_SHR_HI = 3'd4
  } reg_ofs_e;

  localparam int BIT_EN   = 7;
  localparam int BIT_IE   = 1;
  localparam int BIT_FLAG = 0;
  localparam int NUM_BND  = 4;
endpackage

// File: rtl/ramwp_range_cmp.sv
module ramwp_range_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/ramwp_flag.sv
module ramwp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/ramwp_regs.sv
module ramwp_regs
  import ramwp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [AW-1:0] wdata,
  input  logic          flag_i,
  output logic          en_o,
  output logic          ie_o,
  output logic          clr_o,
  output logic [AW-1:0] bnd_o [NUM_BND],
  output logic [AW-1:0] rdata
);
  logic ctrl_sel;
  always_comb ctrl_sel = wr && (addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= 1'b0;
      ie_o <= 1'b0;
    end else if (ctrl_sel) begin
      en_o <= wdata[BIT_EN];
      ie_o <= wdata[BIT_IE];
    end
  end

  always_comb clr_o = ctrl_sel && wdata[BIT_FLAG];

  for (genvar g = 0; g < NUM_BND; g++) begin : g_bnd
    localparam logic [2:0] OFS = 3'(g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bnd_o[g] <= '0;
      else if (wr && (addr == OFS) && !en_o)
        bnd_o[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[BIT_EN]   = en_o;
        rdata[BIT_IE]   = ie_o;
        rdata[BIT_FLAG] = flag_i;
      end
      OFS_COP_LO: rdata = bnd_o[0];
      OFS_COP_HI: rdata = bnd_o[1];
      OFS_SHR_LO: rdata = bnd_o[2];
      OFS_SHR_HI: rdata = bnd_o[3];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ramwp_unit.sv
module ramwp_unit
  import ramwp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          cpu_wr_req,
  input  logic [AW-1:0] cpu_wr_addr,
  output logic          cpu_wr_block,
  input  logic          cop_wr_req,
  input  logic [AW-1:0] cop_wr_addr,
  output logic          cop_wr_block,
  output logic          irq
);
  localparam int NREG = 2;  // coprocessor window, shared window

  logic          prot_en, irq_en, viol_flag, flag_clr;
  logic [AW-1:0] bnd [NUM_BND];
  logic          cpu_in_cop;
  logic [NREG-1:0] cop_hit;

  ramwp_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag_i(viol_flag), .en_o(prot_en), .ie_o(irq_en), .clr_o(flag_clr),
    .bnd_o(bnd), .rdata(reg_rdata)
  );

  ramwp_range_cmp #(.AW(AW)) cpu_cmp_i (
    .lo(bnd[0]), .hi(bnd[1]), .addr(cpu_wr_addr), .hit(cpu_in_cop)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_cop_cmp
    ramwp_range_cmp #(.AW(AW)) cmp_i (
      .lo(bnd[2*r]), .hi(bnd[2*r+1]), .addr(cop_wr_addr), .hit(cop_hit[r])
    );
  end

  always_comb begin
    cpu_wr_block = prot_en && cpu_wr_req && cpu_in_cop;
    cop_wr_block = prot_en && cop_wr_req && (cop_hit == '0);
  end

  ramwp_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set_i(cpu_wr_block), .clr_i(flag_clr),
    .flag_o(viol_flag)
  );

  always_comb irq = irq_en && viol_flag;
endmodule

// File: rtl/ramwp_unit_chk.sv
module ramwp_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [AW-1:0] reg_wdata,
  input logic          prot_en,
  input logic          irq_en,
  input logic          viol_flag,
  input logic          cpu_wr_block,
  input logic          cop_wr_block,
  input logic          irq,
  input logic [AW-1:0] b0,
  input logic [AW-1:0] b1,
  input logic [AW-1:0] b2,
  input logic [AW-1:0] b3
);
  logic clr_wr;
  always_comb clr_wr = reg_wr && (reg_addr == 3'd0) && reg_wdata[0];

  a_r3_off_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |-> (!cpu_wr_block && !cop_wr_block));

  a_r5_block_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_block |=> viol_flag);

  a_r4_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en |=> ($stable(b0) && $stable(b1) && $stable(b2) && $stable(b3)));

  a_r7_cop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_wr_block && !cpu_wr_block && !viol_flag) |=> !viol_flag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_wr) |=> viol_flag);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_en);
endmodule

bind ramwp_unit ramwp_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .prot_en(prot_en), .irq_en(irq_en),
  .viol_flag(viol_flag), .cpu_wr_block(cpu_wr_block),
  .cop_wr_block(cop_wr_block), .irq(irq),
  .b0(bnd[0]), .b1(bnd[1]), .b2(bnd[2]), .b3(bnd[3])
);

// File: tb/ramwp_unit_tb_top.sv
module ramwp_unit_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          cpu_wr_req = 1'b0;
  logic [AW-1:0] cpu_wr_addr = '0;
  logic          cpu_wr_block;
  logic          cop_wr_req = 1'b0;
  logic [AW-1:0] cop_wr_addr = '0;
  logic          cop_wr_block;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ramwp_unit #(.AW(AW)) dut_i (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cpu_try(input logic [AW-1:0] a, output logic blk);
    @(negedge clk);
    cpu_wr_req = 1'b1; cpu_wr_addr = a;
    #1 blk = cpu_wr_block;
    @(negedge clk);
    cpu_wr_req = 1'b0;
  endtask

  task automatic cop_try(input logic [AW-1:0] a, output logic blk);
    @(negedge clk);
    cop_wr_req = 1'b1; cop_wr_addr = a;
    #1 blk = cop_wr_block;
    @(negedge clk);
    cop_wr_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    reg_read(3'd0, v);
    chk("R1 ctrl", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 blocks", {14'd0, cpu_wr_block, cop_wr_block}, 16'd0);
  endtask

  task automatic t_map();
    logic [AW-1:0] v;
    reg_write(3'd1, 16'h1000); reg_write(3'd2, 16'h1FFF);
    reg_write(3'd3, 16'h3000); reg_write(3'd4, 16'h30FF);
    reg_read(3'd1, v); chk("R3 R11 cop lo", v, 16'h1000);
    reg_read(3'd2, v); chk("R11 cop hi", v, 16'h1FFF);
    reg_read(3'd3, v); chk("R11 shr lo", v, 16'h3000);
    reg_read(3'd4, v); chk("R11 shr hi", v, 16'h30FF);
    reg_read(3'd5, v); chk("R11 unmapped", v, 16'h0000);
  endtask

  task automatic t_off();
    logic b;
    cpu_try(16'h1800, b); chk("R3 cpu off", {15'd0, b}, 16'd0);
    cop_try(16'h5000, b); chk("R3 cop off", {15'd0, b}, 16'd0);
  endtask

  task automatic t_ctrl_bits();
    logic [AW-1:0] v;
    reg_write(3'd0, 16'hFFFF);
    reg_read(3'd0, v); chk("R2 ctrl bits", v, 16'h0082);
    reg_write(3'd0, 16'h0080);
    reg_read(3'd0, v); chk("R2 en only", v, 16'h0080);
  endtask

  task automatic t_lock();
    logic [AW-1:0] v;
    reg_write(3'd1, 16'h0000);
    reg_read(3'd1, v); chk("R4 lock lo", v, 16'h1000);
    reg_write(3'd4, 16'hFFFF);
    reg_read(3'd4, v); chk("R4 lock hi", v, 16'h30FF);
  endtask

  task automatic t_cpu();
    logic b; logic [AW-1:0] v;
    cpu_try(16'h0FFF, b); chk("R5 below", {15'd0, b}, 16'd0);
    cpu_try(16'h2000, b); chk("R5 above", {15'd0, b}, 16'd0);
    reg_read(3'd0, v); chk("R5 no flag yet", v, 16'h0080);
    cpu_try(16'h1000, b); chk("R5 lo edge", {15'd0, b}, 16'd1);
    reg_read(3'd0, v); chk("R5 flag set", v, 16'h0081);
    cpu_try(16'h1FFF, b); chk("R5 hi edge", {15'd0, b}, 16'd1);
  endtask

  task automatic t_w1c();
    logic [AW-1:0] v;
    reg_write(3'd0, 16'h0080);
    reg_read(3'd0, v); chk("R8 write0 keeps", v, 16'h0081);
    reg_write(3'd0, 16'h0081);
    reg_read(3'd0, v); chk("R8 write1 clears", v, 16'h0080);
  endtask

  task automatic t_cop();
    logic b; logic [AW-1:0] v;
    cop_try(16'h1000, b); chk("R6 cop lo", {15'd0, b}, 16'd0);
    cop_try(16'h1FFF, b); chk("R6 cop hi", {15'd0, b}, 16'd0);
    cop_try(16'h3000, b); chk("R6 shr lo", {15'd0, b}, 16'd0);
    cop_try(16'h30FF, b); chk("R6 shr hi", {15'd0, b}, 16'd0);
    cop_try(16'h2FFF, b); chk("R6 gap", {15'd0, b}, 16'd1);
    cop_try(16'h3100, b); chk("R6 past shr", {15'd0, b}, 16'd1);
    cop_try(16'h0FFF, b); chk("R6 below cop", {15'd0, b}, 16'd1);
    reg_read(3'd0, v); chk("R7 no flag", v, 16'h0080);
  endtask

  task automatic t_irq();
    logic b;
    reg_write(3'd0, 16'h0082);
    #1 chk("R10 ie only", {15'd0, irq}, 16'd0);
    cpu_try(16'h1500, b);
    #1 chk("R10 irq on", {15'd0, irq}, 16'd1);
    reg_write(3'd0, 16'h0083);
    #1 chk("R10 irq off", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_race();
    logic [AW-1:0] v;
    reg_write(3'd0, 16'h0080);
    @(negedge clk);
    cpu_wr_req = 1'b1; cpu_wr_addr = 16'h1234;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0081;
    @(negedge clk);
    cpu_wr_req = 1'b0; reg_wr = 1'b0;
    reg_read(3'd0, v); chk("R9 set wins", v, 16'h0081);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_off();
    t_ctrl_bits();
    t_lock();
    t_cpu();
    t_w1c();
    t_cop();
    t_irq();
    t_race();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule